// File: doc/BRIEF.md
# Transparent Serial Shifter with Sync Start

This block is a bare serial channel: one transmit holding register feeding a transmit shifter, and one receive shifter feeding a receive holding register. It adds no framing on transmit and strips none on receive. Every word is exactly `W` raw data bits on the line, sent and sampled least significant bit first. The bit rate comes from a one-cycle clock-enable pulse, `bitEn`, produced by an external baud generator.

The channel stays idle, with the transmit line high, until the sync input has been seen high. On the next `bitEn` pulse it starts the first word, and from then on it streams words back to back, with no gap, until reset. Software-side logic writes words into the transmit holding register and watches `txEmpty`. It collects received words from the receive holding register when `rxFull` is set. If no word is waiting when a word boundary arrives, the line stays high for that whole word and an underrun flag is raised.

Top module: `sershift_top`

## Requirements
- R1: After reset, `serTx` is 1, `txEmpty` is 1, `rxFull` is 0 and `txUnderrun` is 0.
- R2: Until `syncIn` has been sampled high, `bitEn` pulses cause no shifting: `serTx` stays 1 and `rxFull` stays 0, whatever `serRx` carries.
- R3: The first word starts on the first `bitEn` pulse after the clock edge where `syncIn` was sampled high. Before that pulse `serTx` stays 1. After it, `serTx` presents bit 0 of the loaded word, and each later `bitEn` pulse advances one bit, least significant bit first. No start or stop bit is inserted.
- R4: `txEmpty` goes to 1 when the holding register is moved into the transmit shifter, and goes to 0 on the cycle after `txWrite`.
- R5: `serRx` is sampled on each `bitEn` pulse that ends a bit slot, least significant bit first. When the `W`-th bit of a word is sampled, `rxData` shows the whole word and `rxFull` becomes 1. A `rxRead` pulse clears `rxFull`.
- R6: Once started, words follow each other with no idle slot. The `bitEn` pulse that ends the last bit of one word also loads the next word.
- R7: If the holding register is empty at a word boundary, `serTx` stays 1 for that entire word and `txUnderrun` becomes 1. It stays 1 until the next `txWrite`.
- R8: After the first word has started, `syncIn` has no further effect and streaming continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | One-cycle bit-rate enable from the baud generator |
| syncIn | input | 1 | Start request; sampled high arms the channel |
| serRx | input | 1 | Serial receive line |
| serTx | output | 1 | Serial transmit line, high when idle |
| txData | input | W | Word to transmit |
| txWrite | input | 1 | Writes `txData` into the transmit holding register |
| txEmpty | output | 1 | Transmit holding register free |
| rxData | output | W | Last complete received word |
| rxRead | input | 1 | Acknowledges the received word |
| rxFull | output | 1 | A received word is waiting |
| txUnderrun | output | 1 | A word boundary found no data to send |

## Verification
The bench loops `serTx` back to `serRx`, so each received word must equal the word sent in the same slot. A bit-order or slot-alignment error would therefore show up as a rotated or shifted word. It spaces the sync pulse well before the first `bitEn`, which catches a design that starts on sync itself or needs both inputs in one cycle. It also leaves the holding register empty at the last boundary, which catches a design that repeats stale data instead of idling high, or one that fails to flag the underrun. Streaming with sync held low shows that the channel does not stall between words.

// File: rtl/sershift_pkg.sv
package sershift_pkg;
  typedef struct packed {
    logic loadWord;  // move holding register (or idle ones) into tx shifter
    logic shiftBit;  // advance both shifters by one bit
    logic wordDone;  // last bit of a word sampled
    logic active;    // channel is streaming
  } shiftStrobes_t;
endpackage

// File: rtl/sershift_ctrl.sv
module sershift_ctrl
  import sershift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitEn,
  input  logic          syncIn,
  output shiftStrobes_t strobes
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic armed;
  logic running;
  logic [CW-1:0] bitCnt;
  logic startNow;
  logic atLast;

  assign startNow = armed && !running && bitEn;
  assign atLast   = running && bitEn && (bitCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      running <= 1'b0;
      bitCnt  <= '0;
    end else begin
      if (!running && syncIn) armed <= 1'b1;
      if (startNow) begin
        running <= 1'b1;
        bitCnt  <= '0;
      end else if (running && bitEn) begin
        bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.loadWord = startNow || atLast;
    strobes.shiftBit = running && bitEn && (bitCnt != LAST);
    strobes.wordDone = atLast;
    strobes.active   = running;
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST);

  // R8
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running);

  // R3
  load_on_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadWord |-> bitEn);
endmodule

// File: rtl/sershift_dp.sv
module sershift_dp
  import sershift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  shiftStrobes_t strobes,
  input  logic          serRx,
  output logic          serTx,
  input  logic [W-1:0]  txData,
  input  logic          txWrite,
  output logic          txEmpty,
  output logic [W-1:0]  rxData,
  input  logic          rxRead,
  output logic          rxFull,
  output logic          txUnderrun
);
  logic [W-1:0] txHold;
  logic [W-1:0] txShift;
  logic [W-1:0] rxShift;
  logic [W-1:0] rxHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold     <= '0;
      txShift    <= '1;
      rxShift    <= '0;
      rxHold     <= '0;
      txEmpty    <= 1'b1;
      rxFull     <= 1'b0;
      txUnderrun <= 1'b0;
    end else begin
      if (txWrite) txHold <= txData;

      if (strobes.loadWord)      txShift <= txEmpty ? '1 : txHold;
      else if (strobes.shiftBit) txShift <= {1'b1, txShift[W-1:1]};

      if (strobes.shiftBit) rxShift <= {serRx, rxShift[W-1:1]};
      if (strobes.wordDone) rxHold  <= {serRx, rxShift[W-1:1]};

      if (txWrite)               txEmpty <= 1'b0;
      else if (strobes.loadWord) txEmpty <= 1'b1;

      if (strobes.wordDone) rxFull <= 1'b1;
      else if (rxRead)      rxFull <= 1'b0;

      if (strobes.loadWord && txEmpty) txUnderrun <= 1'b1;
      else if (txWrite)                txUnderrun <= 1'b0;
    end
  end

  assign serTx  = txShift[0];
  assign rxData = rxHold;

  // R2
  idle_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.active |-> serTx);

  // R7
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadWord && txEmpty) |=> txUnderrun);

  // R4
  write_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    txWrite |=> !txEmpty);

  // R5
  rxfull_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(strobes.wordDone));
endmodule

// File: rtl/sershift_top.sv
module sershift_top
  import sershift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitEn,
  input  logic         syncIn,
  input  logic         serRx,
  output logic         serTx,
  input  logic [W-1:0] txData,
  input  logic         txWrite,
  output logic         txEmpty,
  output logic [W-1:0] rxData,
  input  logic         rxRead,
  output logic         rxFull,
  output logic         txUnderrun
);
  shiftStrobes_t strobes;

  sershift_ctrl #(.W(W)) i_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .syncIn(syncIn), .strobes(strobes)
  );

  sershift_dp #(.W(W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .serRx(serRx), .serTx(serTx),
    .txData(txData), .txWrite(txWrite), .txEmpty(txEmpty),
    .rxData(rxData), .rxRead(rxRead), .rxFull(rxFull),
    .txUnderrun(txUnderrun)
  );
endmodule

// File: tb/test_sershift_top.sv
module test_sershift_top;
  localparam int W = 8;
  localparam int NW = 5;
  // stimulus word and expected received word per slot (loopback)
  localparam logic [2*W-1:0] VEC [NW] = '{
    {8'hA5, 8'hA5}, {8'h3C, 8'h3C}, {8'h01, 8'h01},
    {8'h80, 8'h80}, {8'hD2, 8'hD2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, syncIn = 1'b0, rxDrv = 1'b0, loopOn = 1'b0;
  logic serRx, serTx, txWrite = 1'b0, txEmpty, rxRead = 1'b0, rxFull, txUnderrun;
  logic [W-1:0] txData = '0, rxData;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign serRx = loopOn ? serTx : rxDrv;

  sershift_top #(.W(W)) i_sershift_top (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .syncIn(syncIn), .serRx(serRx),
    .serTx(serTx), .txData(txData), .txWrite(txWrite), .txEmpty(txEmpty),
    .rxData(rxData), .rxRead(rxRead), .rxFull(rxFull), .txUnderrun(txUnderrun)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bitPulse();
    @(negedge clk) bitEn = 1'b1;
    @(negedge clk) bitEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic writeTx(input logic [W-1:0] d);
    @(negedge clk) begin txData = d; txWrite = 1'b1; end
    @(negedge clk) txWrite = 1'b0;
  endtask

  task automatic readRx();
    @(negedge clk) rxRead = 1'b1;
    @(negedge clk) rxRead = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 serTx", W'(serTx), W'(1));
    chk("R1 txEmpty", W'(txEmpty), W'(1));
    chk("R1 rxFull", W'(rxFull), W'(0));
    chk("R1 underrun", W'(txUnderrun), W'(0));

    // R2: bit pulses without sync do nothing, rx line toggling
    for (int k = 0; k < W + 2; k++) begin
      rxDrv = k[0];
      bitPulse();
      chk("R2 serTx idle", W'(serTx), W'(1));
    end
    chk("R2 rxFull", W'(rxFull), W'(0));

    writeTx(VEC[0][2*W-1:W]);
    chk("R4 write clears empty", W'(txEmpty), W'(0));

    loopOn = 1'b1;
    @(negedge clk) syncIn = 1'b1;
    @(negedge clk) syncIn = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 waits for bitEn", W'(serTx), W'(1));

    bitPulse(); // start edge
    chk("R4 empty on load", W'(txEmpty), W'(1));
    chk("R3 first bit", W'(serTx), W'(VEC[0][W]));
    writeTx(VEC[1][2*W-1:W]);

    for (int i = 0; i < NW; i++) begin
      for (int b = 0; b < W; b++) begin
        chk("R3 R6 tx bit", W'(serTx), W'(VEC[i][W+b]));
        if (b == W - 1) chk("R5 not yet full", W'(rxFull), W'(0));
        bitPulse();
      end
      chk("R5 rxFull", W'(rxFull), W'(1));
      chk("R5 rxData", rxData, VEC[i][W-1:0]);
      readRx();
      chk("R5 read clears", W'(rxFull), W'(0));
      if (i + 2 < NW) writeTx(VEC[i+2][2*W-1:W]);
    end

    // R7: boundary of last word found nothing to send; R8 sync low all along
    chk("R7 underrun", W'(txUnderrun), W'(1));
    for (int b = 0; b < W; b++) begin
      chk("R7 line high", W'(serTx), W'(1));
      bitPulse();
    end
    chk("R8 still streaming", W'(rxFull), W'(1));
    chk("R7 idle word received", rxData, '1);
    writeTx(8'h5A);
    chk("R7 write clears underrun", W'(txUnderrun), W'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule